// File: doc/BRIEF.md
# Transmit DMA Channel Controller

This block is the control and status core of a single transmit DMA channel. It walks a table of transfer descriptors, each giving a byte count, an invalid marker and a last-entry marker. It streams each descriptor's bytes into a 64-byte transmit FIFO by issuing memory fetch requests. A fetch goes out only once the FIFO has at least a programmable amount of free space. The output serialiser drains the FIFO one byte per accepted cycle.

Software sees two 16-bit registers. The control word holds the enable, table mode (linear or circular), threshold code, the software-abort and clear-abort strobes, and the read-only abort, table-full and active flags. The status word holds the FIFO byte level, the invalid-descriptor mask and the outstanding-retry flag. The bus master, the descriptor store and the serialiser are modelled as plain handshake ports.

Top module: `tx_dma_ctrl`

## Requirements
- R1: After reset both registers read 0x0000, and `desc_req_o`, `fetch_req_o` and `byte_valid_o` are 0.
- R2: A fetch request is raised only when FIFO free space (64 minus level) is at least the threshold selected by control bits [3:2]: 00=16, 01=32, 10=48, 11=60 bytes. Its length is the smaller of the descriptor's remaining bytes and the free space.
- R3: Status bits [6:0] give the FIFO byte level. It rises by `fetch_len_o` on an accepted fetch and falls by 1 on each cycle with `byte_take_i` high and a non-zero level. Both apply when they fall in the same cycle.
- R4: The abort flag (control bit 8) is sticky. It is set by `fetch_err_i` on an outstanding fetch, by `contention_i`, or by writing 1 to control bit 4. While it is set, the level is 0, no descriptor or new fetch request is issued, and the active flag is 0.
- R5: Writing 1 to control bit 5 clears the abort flag at the second clock edge after the write. Bits 4 and 5 always read 0. An abort event in the same cycle as the clearing pulse wins.
- R6: In linear mode (control bit 1 = 0), once all bytes of the last-entry descriptor have been fetched and the FIFO is empty, control bit 9 is set. Writing 1 to bit 9 clears it, and writing 0 has no effect. It is never set in circular mode.
- R7: Control bit 10 reads 1 from channel start until the table completes or an abort occurs.
- R8: With status bit 8 = 0, a descriptor flagged invalid is skipped with no fetch. With bit 8 = 1, its bytes are fetched like any other.
- R9: Status bit 15 is 1 while a fetch that saw `fetch_retry_i` is still outstanding. It clears when that fetch is accepted or errors. While it is set, the channel does not start, and data from a fetch outstanding across an abort is discarded.
- R10: In circular mode, the descriptor after a last-entry descriptor is index 0.
- R11: The channel starts at descriptor 0 only when control bit 0 is 1 and neither abort nor table-full is set. Unassigned bits read 0, and only status bit 8 is writable in the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 = control word, 1 = status word |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data of the selected word |
| desc_req_o | output | 1 | Descriptor read request |
| desc_idx_o | output | IDX_W (4) | Descriptor index |
| desc_ack_i | input | 1 | Descriptor fields valid |
| desc_len_i | input | LEN_W (12) | Descriptor byte count |
| desc_inv_i | input | 1 | Descriptor invalid marker |
| desc_eot_i | input | 1 | Last descriptor of table |
| fetch_req_o | output | 1 | Memory fetch request |
| fetch_len_o | output | CNT_W (7) | Bytes requested |
| fetch_ack_i | input | 1 | Fetch accepted, bytes enter FIFO |
| fetch_retry_i | input | 1 | Target retry on pending fetch |
| fetch_err_i | input | 1 | Bus error on pending fetch |
| byte_valid_o | output | 1 | FIFO holds a byte for the serialiser |
| byte_take_i | input | 1 | Serialiser takes one byte |
| contention_i | input | 1 | Output channel contention, aborts |

## Verification
The main collision is a fetch acceptance and a serialiser byte take in the same cycle. The bench stalls a table on a full FIFO, then opens the drain and lets the refill arrive while bytes leave. It then compares the level with the sum of both effects. The second collision is the clear-abort pulse landing on the same edge as a contention event. The bench drives contention exactly one cycle after the clearing write and expects the flag to stay set.

// File: rtl/tx_dma_pkg.sv
package tx_dma_pkg;
  localparam int unsigned REG_W = 16;

  // control word bit positions
  localparam int unsigned C_EN    = 0;
  localparam int unsigned C_CIRC  = 1;
  localparam int unsigned C_THR   = 2;
  localparam int unsigned C_SWAB  = 4;
  localparam int unsigned C_CLRAB = 5;
  localparam int unsigned C_ABORT = 8;
  localparam int unsigned C_FULL  = 9;
  localparam int unsigned C_ACT   = 10;
  // status word bit positions
  localparam int unsigned S_MASK  = 8;
  localparam int unsigned S_OPEN  = 15;

  typedef enum logic [1:0] {ST_IDLE, ST_DESC, ST_XFER, ST_DRAIN} seq_state_e;

  typedef struct packed {
    logic       en;
    logic       circ;
    logic [1:0] thr;
    logic       inv_mask;
  } cfg_t;

  // quarter steps, top code leaves one sixteenth
  function automatic int unsigned thr_bytes(logic [1:0] code, int unsigned depth);
    return (code == 2'b11) ? depth - depth / 16 : (int'(code) + 1) * depth / 4;
  endfunction
endpackage

// File: rtl/tx_dma_regs.sv
module tx_dma_regs
  import tx_dma_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output cfg_t             cfg_o,
  input  logic             abort_evt_i,
  input  logic             done_evt_i,
  input  logic             active_i,
  input  logic             open_i,
  input  logic [CNT_W-1:0] level_i,
  output logic             abort_o,
  output logic             abort_set_o,
  output logic             clr_pulse_o,
  output logic             full_o
);
  logic en_q, circ_q, mask_q, abort_q, full_q, clr_q;
  logic [1:0] thr_q;
  logic wr_ctrl, wr_stat, sw_abort, full_w1c;
  logic unused_wbits;

  assign wr_ctrl  = wr_i && !sel_i;
  assign wr_stat  = wr_i && sel_i;
  assign sw_abort = wr_ctrl && wdata_i[C_SWAB];
  assign full_w1c = wr_ctrl && wdata_i[C_FULL];
  assign unused_wbits = ^{wdata_i[15:10], wdata_i[7:6]};

  assign abort_set_o = abort_evt_i || sw_abort;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      circ_q  <= 1'b0;
      thr_q   <= 2'b00;
      mask_q  <= 1'b0;
      abort_q <= 1'b0;
      full_q  <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= wdata_i[C_EN];
        circ_q <= wdata_i[C_CIRC];
        thr_q  <= wdata_i[C_THR +: 2];
      end
      if (wr_stat) mask_q <= wdata_i[S_MASK];
      clr_q <= wr_ctrl && wdata_i[C_CLRAB];
      // set wins over clear
      if (abort_set_o)  abort_q <= 1'b1;
      else if (clr_q)   abort_q <= 1'b0;
      if (done_evt_i)   full_q  <= 1'b1;
      else if (full_w1c) full_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (!sel_i) begin
      rdata_o[C_EN]       = en_q;
      rdata_o[C_CIRC]     = circ_q;
      rdata_o[C_THR +: 2] = thr_q;
      rdata_o[C_ABORT]    = abort_q;
      rdata_o[C_FULL]     = full_q;
      rdata_o[C_ACT]      = active_i;
    end else begin
      rdata_o[CNT_W-1:0]  = level_i;
      rdata_o[S_MASK]     = mask_q;
      rdata_o[S_OPEN]     = open_i;
    end
  end

  assign cfg_o       = '{en: en_q, circ: circ_q, thr: thr_q, inv_mask: mask_q};
  assign abort_o     = abort_q;
  assign clr_pulse_o = clr_q;
  assign full_o      = full_q;
endmodule

// File: rtl/tx_dma_level.sv
module tx_dma_level
  import tx_dma_pkg::*;
#(
  parameter int unsigned FIFO_BYTES = 64,
  parameter int unsigned CNT_W      = $clog2(FIFO_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             add_i,
  input  logic [CNT_W-1:0] add_len_i,
  input  logic             take_i,
  input  logic             flush_i,
  input  logic [1:0]       thr_i,
  output logic [CNT_W-1:0] level_o,
  output logic [CNT_W-1:0] free_o,
  output logic             room_ok_o
);
  logic [CNT_W-1:0] lvl_q;
  logic [CNT_W-1:0] thr_tab [4];
  logic             take;

  for (genvar g = 0; g < 4; g++) begin : g_thr
    assign thr_tab[g] = CNT_W'(thr_bytes(2'(g), FIFO_BYTES));
  end

  assign take = take_i && (lvl_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lvl_q <= '0;
    else if (flush_i) lvl_q <= '0;
    else              lvl_q <= lvl_q + (add_i ? add_len_i : '0) - CNT_W'(take);
  end

  assign level_o   = lvl_q;
  assign free_o    = CNT_W'(FIFO_BYTES) - lvl_q;
  assign room_ok_o = free_o >= thr_tab[thr_i];
endmodule

// File: rtl/tx_dma_seq.sv
module tx_dma_seq
  import tx_dma_pkg::*;
#(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned LEN_W = 12,
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cfg_t             cfg_i,
  input  logic             abort_i,
  input  logic             abort_set_i,
  input  logic             full_i,
  input  logic             room_ok_i,
  input  logic [CNT_W-1:0] free_i,
  input  logic             lvl_zero_i,
  output logic             desc_req_o,
  output logic [IDX_W-1:0] desc_idx_o,
  input  logic             desc_ack_i,
  input  logic [LEN_W-1:0] desc_len_i,
  input  logic             desc_inv_i,
  input  logic             desc_eot_i,
  output logic             fetch_req_o,
  output logic [CNT_W-1:0] fetch_len_o,
  input  logic             fetch_ack_i,
  input  logic             fetch_retry_i,
  input  logic             fetch_err_i,
  output logic             add_o,
  output logic [CNT_W-1:0] add_len_o,
  output logic             done_o,
  output logic             bus_err_o,
  output logic             active_o,
  output logic             open_o
);
  seq_state_e       st_q;
  logic [IDX_W-1:0] idx_q;
  logic [LEN_W-1:0] rem_q;
  logic             eot_q, req_q, open_q, stale_q;
  logic [CNT_W-1:0] len_q, chunk;
  logic             halt, start_ok, f_ack, f_err, issue, skip;

  assign halt     = abort_i || abort_set_i;
  assign start_ok = cfg_i.en && !halt && !full_i && !open_q && !req_q;
  assign f_ack    = req_q && fetch_ack_i;
  assign f_err    = req_q && fetch_err_i;
  assign chunk    = (rem_q < LEN_W'(free_i)) ? CNT_W'(rem_q) : free_i;
  assign issue    = (st_q == ST_XFER) && !req_q && (rem_q != '0) && room_ok_i && !halt;
  assign skip     = desc_inv_i && !cfg_i.inv_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      rem_q <= '0;
      eot_q <= 1'b0;
    end else if (halt) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      rem_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_ok) begin
          st_q  <= ST_DESC;
          idx_q <= '0;
        end
        ST_DESC: if (desc_ack_i) begin
          rem_q <= skip ? '0 : desc_len_i;
          eot_q <= desc_eot_i;
          st_q  <= ST_XFER;
        end
        ST_XFER: begin
          if (f_ack) begin
            rem_q <= rem_q - LEN_W'(len_q);
          end else if (rem_q == '0 && !req_q) begin
            if (!eot_q) begin
              idx_q <= idx_q + 1'b1;
              st_q  <= ST_DESC;
            end else if (cfg_i.circ) begin
              idx_q <= '0;
              st_q  <= ST_DESC;
            end else begin
              st_q  <= ST_DRAIN;
            end
          end
        end
        ST_DRAIN: if (lvl_zero_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // outstanding bus cycle tracking
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      len_q   <= '0;
      open_q  <= 1'b0;
      stale_q <= 1'b0;
    end else begin
      if (issue) begin
        req_q <= 1'b1;
        len_q <= chunk;
      end else if (f_ack || f_err) begin
        req_q <= 1'b0;
      end
      if (f_ack || f_err)              open_q <= 1'b0;
      else if (req_q && fetch_retry_i) open_q <= 1'b1;
      if (f_ack || f_err)              stale_q <= 1'b0;
      else if (req_q && halt)          stale_q <= 1'b1;
    end
  end

  assign desc_req_o  = (st_q == ST_DESC);
  assign desc_idx_o  = idx_q;
  assign fetch_req_o = req_q;
  assign fetch_len_o = len_q;
  assign add_o       = f_ack && !stale_q && !halt;
  assign add_len_o   = len_q;
  assign done_o      = (st_q == ST_DRAIN) && lvl_zero_i && !halt;
  assign bus_err_o   = f_err;
  assign active_o    = (st_q != ST_IDLE);
  assign open_o      = open_q;
endmodule

// File: rtl/tx_dma_ctrl.sv
module tx_dma_ctrl
  import tx_dma_pkg::*;
#(
  parameter int unsigned FIFO_BYTES = 64,
  parameter int unsigned IDX_W      = 4,
  parameter int unsigned LEN_W      = 12,
  localparam int unsigned CNT_W     = $clog2(FIFO_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic             reg_sel_i,
  input  logic [15:0]      reg_wdata_i,
  output logic [15:0]      reg_rdata_o,
  output logic             desc_req_o,
  output logic [IDX_W-1:0] desc_idx_o,
  input  logic             desc_ack_i,
  input  logic [LEN_W-1:0] desc_len_i,
  input  logic             desc_inv_i,
  input  logic             desc_eot_i,
  output logic             fetch_req_o,
  output logic [CNT_W-1:0] fetch_len_o,
  input  logic             fetch_ack_i,
  input  logic             fetch_retry_i,
  input  logic             fetch_err_i,
  output logic             byte_valid_o,
  input  logic             byte_take_i,
  input  logic             contention_i
);
  cfg_t             cfg;
  logic [CNT_W-1:0] level, free, add_len;
  logic             room_ok, add, done, bus_err, active, open;
  logic             abort_q, abort_set, clr_pulse, full_q;

  tx_dma_regs #(.CNT_W(CNT_W)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i),
    .sel_i       (reg_sel_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .cfg_o       (cfg),
    .abort_evt_i (bus_err || contention_i),
    .done_evt_i  (done),
    .active_i    (active),
    .open_i      (open),
    .level_i     (level),
    .abort_o     (abort_q),
    .abort_set_o (abort_set),
    .clr_pulse_o (clr_pulse),
    .full_o      (full_q)
  );

  tx_dma_level #(.FIFO_BYTES(FIFO_BYTES), .CNT_W(CNT_W)) i_level (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .add_i     (add),
    .add_len_i (add_len),
    .take_i    (byte_take_i && !abort_q),
    .flush_i   (abort_set || abort_q),
    .thr_i     (cfg.thr),
    .level_o   (level),
    .free_o    (free),
    .room_ok_o (room_ok)
  );

  tx_dma_seq #(.IDX_W(IDX_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) i_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_i         (cfg),
    .abort_i       (abort_q),
    .abort_set_i   (abort_set),
    .full_i        (full_q),
    .room_ok_i     (room_ok),
    .free_i        (free),
    .lvl_zero_i    (level == '0),
    .desc_req_o    (desc_req_o),
    .desc_idx_o    (desc_idx_o),
    .desc_ack_i    (desc_ack_i),
    .desc_len_i    (desc_len_i),
    .desc_inv_i    (desc_inv_i),
    .desc_eot_i    (desc_eot_i),
    .fetch_req_o   (fetch_req_o),
    .fetch_len_o   (fetch_len_o),
    .fetch_ack_i   (fetch_ack_i),
    .fetch_retry_i (fetch_retry_i),
    .fetch_err_i   (fetch_err_i),
    .add_o         (add),
    .add_len_o     (add_len),
    .done_o        (done),
    .bus_err_o     (bus_err),
    .active_o      (active),
    .open_o        (open)
  );

  assign byte_valid_o = (level != '0) && !abort_q;
endmodule

// File: rtl/tx_dma_ctrl_chk.sv
module tx_dma_ctrl_chk
  import tx_dma_pkg::*;
#(
  parameter int unsigned FIFO_BYTES = 64,
  parameter int unsigned CNT_W      = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fetch_req,
  input logic             desc_req,
  input logic [CNT_W-1:0] level,
  input logic [1:0]       thr,
  input logic             circ,
  input logic             abort,
  input logic             abort_set,
  input logic             clr_pulse,
  input logic             full,
  input logic             open,
  input logic             active
);
  // R3
  level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(level) <= FIFO_BYTES);

  // R2
  fetch_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fetch_req) |-> (FIFO_BYTES - int'($past(level))) >= thr_bytes($past(thr), FIFO_BYTES));

  // R4
  abort_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |-> (level == '0) && !desc_req && !active);

  // R4
  abort_nofetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> !$rose(fetch_req));

  // R5
  clr_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_pulse && !abort_set) |=> !abort);

  // R6
  circ_nofull_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full) |-> !$past(circ));

  // R9
  open_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open |-> fetch_req);

  // R7
  idle_nodesc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> !desc_req);
endmodule

bind tx_dma_ctrl tx_dma_ctrl_chk #(.FIFO_BYTES(FIFO_BYTES), .CNT_W(CNT_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fetch_req (fetch_req_o),
  .desc_req  (desc_req_o),
  .level     (level),
  .thr       (cfg.thr),
  .circ      (cfg.circ),
  .abort     (abort_q),
  .abort_set (abort_set),
  .clr_pulse (clr_pulse),
  .full      (full_q),
  .open      (open),
  .active    (active)
);

// File: tb/test_tx_dma_ctrl.sv
module test_tx_dma_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 4;
  localparam int LEN_W = 12;
  localparam int CNT_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_sel = 1'b1;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic desc_req, desc_ack = 1'b0, desc_inv = 1'b0, desc_eot = 1'b0;
  logic [IDX_W-1:0] desc_idx;
  logic [LEN_W-1:0] desc_len = '0;
  logic fetch_req, fetch_ack = 1'b0, fetch_retry = 1'b0, fetch_err = 1'b0;
  logic [CNT_W-1:0] fetch_len;
  logic byte_valid, contention = 1'b0;
  logic drain_en = 1'b0, hold_fetch = 1'b0, err_mode = 1'b0;

  int d_len [16];
  bit d_inv [16];
  bit d_eot [16];
  int exp_q [$];
  int fetch_cnt = 0;
  int n_chk = 0, n_fail = 0;

  tx_dma_ctrl i_tx_dma_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .desc_req_o(desc_req), .desc_idx_o(desc_idx), .desc_ack_i(desc_ack),
    .desc_len_i(desc_len), .desc_inv_i(desc_inv), .desc_eot_i(desc_eot),
    .fetch_req_o(fetch_req), .fetch_len_o(fetch_len), .fetch_ack_i(fetch_ack),
    .fetch_retry_i(fetch_retry), .fetch_err_i(fetch_err),
    .byte_valid_o(byte_valid), .byte_take_i(drain_en), .contention_i(contention)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // descriptor store and bus target models, monitor for fetch lengths
  always @(negedge clk) begin
    desc_len = LEN_W'(d_len[desc_idx]);
    desc_inv = d_inv[desc_idx];
    desc_eot = d_eot[desc_idx];
    desc_ack = desc_req && !desc_ack;
    fetch_retry = fetch_req && hold_fetch;
    fetch_err = fetch_req && err_mode && !fetch_err;
    if (fetch_req && !hold_fetch && !err_mode && !fetch_ack) begin
      fetch_ack = 1'b1;
      fetch_cnt++;
      if (exp_q.size() > 0) check("R2 fetch length", int'(fetch_len), exp_q.pop_front());
    end else begin
      fetch_ack = 1'b0;
    end
  end

  task automatic wr(bit sel, logic [15:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b1;
  endtask

  // read at the current negedge
  task automatic rd(bit sel, output int v);
    reg_sel = sel;
    #1 v = int'(reg_rdata);
    reg_sel = 1'b1;
  endtask

  task automatic wait_q_empty(string req);
    for (int i = 0; i < 2000; i++) begin
      if (exp_q.size() == 0) break;
      @(negedge clk);
    end
    check(req, exp_q.size(), 0);
  endtask

  task automatic set_desc(int i, int len, bit inv, bit eot);
    d_len[i] = len; d_inv[i] = inv; d_eot[i] = eot;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v, f0;
    for (int i = 0; i < 16; i++) set_desc(i, 0, 0, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(0, v); check("R1 control", v, 0);
    rd(1, v); check("R1 status", v, 0);
    check("R1 outputs", {desc_req, fetch_req, byte_valid}, 0);

    // R11 only mask writable in status word
    wr(1, 16'hFFFF);
    @(negedge clk); rd(1, v); check("R11 status write", v, 16'h0100);
    wr(1, 16'h0000);

    // linear table, threshold 16, drain held off
    set_desc(0, 40, 0, 0); set_desc(1, 30, 0, 1);
    exp_q.push_back(40); exp_q.push_back(24);
    wr(0, 16'h0001);
    wait_q_empty("R2 first fetches");
    repeat (10) @(negedge clk);
    rd(1, v); check("R3 full level", v, 64);
    check("R2 no fetch without room", fetch_req, 0);
    exp_q.push_back(6);
    drain_en = 1'b1;
    for (int i = 0; i < 200 && !fetch_req; i++) @(negedge clk);
    rd(1, v); check("R2 issue at 16 free", v, 47);
    @(negedge clk);
    rd(1, v); check("R3 add and take same cycle", v, 52);
    repeat (120) @(negedge clk);
    rd(0, v); check("R6 table full linear", v, 16'h0201);
    wr(0, 16'h0000);
    @(negedge clk); rd(0, v); check("R6 write 0 keeps full", v, 16'h0200);
    wr(0, 16'h0200);
    @(negedge clk); rd(0, v); check("R6 W1C full", v, 0);

    // circular, invalid skipped, threshold 32
    set_desc(0, 8, 0, 0); set_desc(1, 10, 1, 0); set_desc(2, 4, 0, 1);
    exp_q.push_back(8); exp_q.push_back(4); exp_q.push_back(8); exp_q.push_back(4);
    wr(0, 16'h0007);
    wait_q_empty("R8 R10 skip and wrap");
    rd(0, v); check("R7 R10 active no full", v, 16'h0407);
    wr(0, 16'h0017);
    repeat (2) @(negedge clk);
    rd(0, v); check("R4 sw abort", v, 16'h0107);
    rd(1, v); check("R4 flush", v, 0);
    f0 = fetch_cnt;
    repeat (20) @(negedge clk);
    check("R4 no fetch during abort", fetch_cnt, f0);
    check("R4 no desc during abort", desc_req, 0);
    wr(1, 16'h0100);
    exp_q.push_back(8); exp_q.push_back(10); exp_q.push_back(4);
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = 16'h0027;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(0, v); check("R5 abort held one edge", v, 16'h0107);
    @(negedge clk);
    rd(0, v); check("R5 abort cleared", v, 16'h0007);
    wait_q_empty("R8 invalid sent with mask");

    // contention abort, then set-wins collision
    contention = 1'b1; @(negedge clk); contention = 1'b0;
    rd(0, v); check("R4 contention abort", (v >> 8) & 1, 1);
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = 16'h0020;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b1; contention = 1'b1;
    @(negedge clk);
    contention = 1'b0;
    rd(0, v); check("R5 set wins over clear", v, 16'h0100);
    wr(0, 16'h0020);
    @(negedge clk); rd(0, v); check("R5 clear with disable", v, 0);

    // bus error abort
    set_desc(0, 8, 0, 1);
    err_mode = 1'b1;
    wr(0, 16'h0001);
    repeat (8) @(negedge clk);
    rd(0, v); check("R4 bus error abort", v, 16'h0101);
    err_mode = 1'b0;
    wr(0, 16'h0020);
    @(negedge clk); rd(0, v); check("R11 no start when disabled", v, 0);

    // retry keeps cycle open, blocks restart
    hold_fetch = 1'b1;
    wr(0, 16'h0001);
    repeat (8) @(negedge clk);
    rd(1, v); check("R9 open set", v, 16'h8100);
    wr(0, 16'h0010);
    wr(0, 16'h0021);
    repeat (10) @(negedge clk);
    rd(0, v); check("R9 start blocked while open", v, 16'h0001);
    exp_q.push_back(8); exp_q.push_back(8);
    hold_fetch = 1'b0;
    wait_q_empty("R9 outstanding then restart");
    rd(1, v); check("R9 open cleared", (v >> 15) & 1, 0);
    repeat (150) @(negedge clk);
    rd(0, v); check("R6 R9 restarted table done", v, 16'h0201);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule